// File: doc/BRIEF.md
# Failed Memory Chip Tracker with Parity Pre-Repair

This block sits beside the read path of a memory controller whose lines are spread across several chips. Each line holds eight data slices and one slice of authentication tag. An external trial search repairs corrupted lines by rebuilding one chip's slice at a time from a separate parity word. Each time that search succeeds, it reports the index of the chip it repaired. The tracker keeps a saturating count of these reports for each chip. When one chip's count reaches a programmable threshold, the tracker marks that chip as failed.

While a chip is marked, every read line has that chip's slice replaced with the value rebuilt from parity before the line leaves the block. The single integrity check that every read already needs then confirms the rebuilt line, so the multi-trial search is no longer run. If the checker still reports a mismatch on a repaired line, the tracker drops the mark, zeroes that chip's count and pulses a request so that the full search runs again. A synchronous clear wipes all learned state. When no chip is marked, lines pass through unchanged with one cycle of registered latency.

Top module: `fault_chip_tracker`

## Requirements
- R1: During and right after reset, `failValid`, `outValid` and `searchReq` are 0.
- R2: While no chip is marked, a line presented with `rdValid` appears unchanged on `outLine` in the next cycle, with `outValid`=1 and `outPatched`=0. `outValid` is 0 in a cycle that follows one without `rdValid`.
- R3: A cycle with `corrValid`=1 and `corrChip` in 0..NUM_CHIPS-1 increments that chip's count. If no chip is marked and the incremented count is >= `thresh`, that chip becomes marked. From the next cycle `failValid`=1 and `failChip` equals the chip index.
- R4: A correction event whose `corrChip` is NUM_CHIPS or larger changes no count and no mark.
- R5: Only one chip is marked at a time. While a mark is held, further events on any chip, including ones that reach the threshold, leave `failChip` unchanged. The first chip to reach the threshold keeps the mark.
- R6: Counts are CNT_W bits wide (8 by default) and saturate at all-ones. They do not wrap.
- R7: With chip k marked, `outLine` equals `rdLine` except that slice k (bits k*SLICE_W upward, where slices 0..7 are data and slice 8 is the tag chip) is replaced by `rdParity` XOR all the other slices. `outPatched`=1.
- R8: `macResValid`=1 with `macMismatch`=1 while a chip is marked clears the mark and zeroes that chip's count. `searchReq` is 1 for exactly the next cycle.
- R9: A mismatch report while no chip is marked is ignored. `searchReq` stays 0.
- R10: `clearIn` synchronously zeroes all counts and the mark. It takes priority over a correction event in the same cycle.
- R11: `thresh` is compared at the moment of each event. With `thresh`=1, the first correction on a chip marks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clearIn | input | 1 | Synchronous wipe of counts and mark |
| thresh | input | CNT_W | Count at which a chip is declared failed |
| corrValid | input | 1 | A successful search repair is reported this cycle |
| corrChip | input | $clog2(NUM_CHIPS) | Chip index repaired by the search |
| rdValid | input | 1 | Read line present |
| rdLine | input | NUM_CHIPS*SLICE_W | Read line, slice i from chip i |
| rdParity | input | SLICE_W | Parity word over all chip slices of the line |
| macResValid | input | 1 | Integrity check result valid for a repaired line |
| macMismatch | input | 1 | Integrity check failed |
| outValid | output | 1 | Registered line valid |
| outLine | output | NUM_CHIPS*SLICE_W | Line after optional pre-repair |
| outPatched | output | 1 | Slice of the marked chip was rebuilt |
| failValid | output | 1 | A chip is marked failed |
| failChip | output | $clog2(NUM_CHIPS) | Index of the marked chip |
| searchReq | output | 1 | One-cycle request to rerun the full trial search |

## Verification
Two conditions are the hardest to reach from the ports. The first is proving that counts saturate instead of wrapping, because a count is only visible through the moment a chip becomes marked. The bench holds a mark on one chip, sends 300 events to a second chip with the threshold at 255, then releases the mark through a mismatch report. One further event must then mark the second chip, which a wrapped count would fail to do. The second condition is the priority between clear and correction in the same cycle. It is reached by asserting both together at a threshold of 1 and checking that no mark appears.

// File: rtl/fct_pkg.sv
package fct_pkg;
  localparam int unsigned CHIP_ID_W = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 patchEn;
    logic [CHIP_ID_W-1:0] patchChip;
  } patchCmd_t;
endpackage

// File: rtl/fct_ctrl.sv
module fct_ctrl
  import fct_pkg::*;
#(
  parameter int unsigned NUM_CHIPS = 9,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned IDX_W     = $clog2(NUM_CHIPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearIn,
  input  logic [CNT_W-1:0] thresh,
  input  logic             corrValid,
  input  logic [IDX_W-1:0] corrChip,
  input  logic             macResValid,
  input  logic             macMismatch,
  output logic             failValid,
  output logic [IDX_W-1:0] failChip,
  output logic             searchReq,
  output patchCmd_t        patchCmd
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt [NUM_CHIPS];
  logic             markQ;
  logic [IDX_W-1:0] chipQ;
  logic             searchQ;
  logic             corrHit;
  logic             unmarkHit;
  logic [CNT_W-1:0] evtCnt;
  logic [CNT_W-1:0] evtNext;

  assign corrHit   = corrValid && ({1'b0, corrChip} < (IDX_W+1)'(NUM_CHIPS));
  assign unmarkHit = macResValid && macMismatch && markQ;

  // Current count of the chip named by the event
  always_comb begin
    evtCnt = '0;
    for (int i = 0; i < int'(NUM_CHIPS); i++) begin
      if (corrChip == IDX_W'(i)) evtCnt = cnt[i];
    end
    evtNext = (evtCnt == CNT_MAX) ? CNT_MAX : evtCnt + CNT_W'(1);
  end

  for (genvar i = 0; i < int'(NUM_CHIPS); i++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         cnt[i] <= '0;
      else if (clearIn)                                  cnt[i] <= '0;
      else if (unmarkHit && chipQ == IDX_W'(i))          cnt[i] <= '0;
      else if (corrHit && corrChip == IDX_W'(i) && cnt[i] != CNT_MAX)
                                                         cnt[i] <= cnt[i] + CNT_W'(1);
    end

    // R6
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[i] == CNT_MAX && !clearIn && !unmarkHit) |=> cnt[i] == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markQ <= 1'b0;
      chipQ <= '0;
    end else if (clearIn || unmarkHit) begin
      markQ <= 1'b0;
    end else if (!markQ && corrHit && evtNext >= thresh) begin
      markQ <= 1'b1;
      chipQ <= corrChip;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) searchQ <= 1'b0;
    else       searchQ <= unmarkHit && !clearIn;
  end

  assign failValid          = markQ;
  assign failChip           = chipQ;
  assign searchReq          = searchQ;
  assign patchCmd.patchEn   = markQ;
  assign patchCmd.patchChip = CHIP_ID_W'(chipQ);

  // R5
  mark_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failValid && !clearIn && !(macResValid && macMismatch)) |=> (failValid && $stable(failChip)));
  // R8
  search_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    searchReq |=> !searchReq);
  // R10
  clear_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (!failValid && !searchReq));
  // R9
  no_spurious_search_chk: assert property (@(posedge clk) disable iff (!rstN)
    !failValid |=> !searchReq);
  // R3
  fail_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    failValid |-> ({1'b0, failChip} < (IDX_W+1)'(NUM_CHIPS)));
endmodule

// File: rtl/fct_datapath.sv
module fct_datapath
  import fct_pkg::*;
#(
  parameter int unsigned NUM_CHIPS = 9,
  parameter int unsigned SLICE_W   = 64,
  parameter int unsigned LINE_W    = NUM_CHIPS * SLICE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic [LINE_W-1:0] rdLine,
  input  logic [SLICE_W-1:0] rdParity,
  input  patchCmd_t         patchCmd,
  output logic              outValid,
  output logic [LINE_W-1:0] outLine,
  output logic              outPatched
);
  logic [SLICE_W-1:0] rebuilt;
  logic [LINE_W-1:0]  fixedLine;

  // Parity XOR every slice except the marked one
  always_comb begin
    rebuilt = rdParity;
    for (int i = 0; i < int'(NUM_CHIPS); i++) begin
      if (patchCmd.patchChip != CHIP_ID_W'(i)) rebuilt = rebuilt ^ rdLine[i*SLICE_W +: SLICE_W];
    end
  end

  for (genvar i = 0; i < int'(NUM_CHIPS); i++) begin : g_slice
    assign fixedLine[i*SLICE_W +: SLICE_W] =
      (patchCmd.patchEn && patchCmd.patchChip == CHIP_ID_W'(i)) ? rebuilt
                                                                : rdLine[i*SLICE_W +: SLICE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outPatched <= 1'b0;
    end else begin
      outValid   <= rdValid;
      outPatched <= rdValid && patchCmd.patchEn;
    end
  end

  always_ff @(posedge clk) begin
    if (rdValid) outLine <= fixedLine;
  end

  function automatic logic [SLICE_W-1:0] sliceXor(input logic [LINE_W-1:0] l);
    logic [SLICE_W-1:0] acc = '0;
    for (int i = 0; i < int'(NUM_CHIPS); i++) acc = acc ^ l[i*SLICE_W +: SLICE_W];
    return acc;
  endfunction

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outPatched) |-> outLine == $past(rdLine));
  // R7
  patch_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outPatched) |-> sliceXor(outLine) == $past(rdParity));
endmodule

// File: rtl/fault_chip_tracker.sv
module fault_chip_tracker
  import fct_pkg::*;
#(
  parameter int unsigned NUM_CHIPS = 9,
  parameter int unsigned SLICE_W   = 64,
  parameter int unsigned CNT_W     = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_CHIPS),
  localparam int unsigned LINE_W   = NUM_CHIPS * SLICE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearIn,
  input  logic [CNT_W-1:0]   thresh,
  input  logic               corrValid,
  input  logic [IDX_W-1:0]   corrChip,
  input  logic               rdValid,
  input  logic [LINE_W-1:0]  rdLine,
  input  logic [SLICE_W-1:0] rdParity,
  input  logic               macResValid,
  input  logic               macMismatch,
  output logic               outValid,
  output logic [LINE_W-1:0]  outLine,
  output logic               outPatched,
  output logic               failValid,
  output logic [IDX_W-1:0]   failChip,
  output logic               searchReq
);
  patchCmd_t patchCmd;

  fct_ctrl #(.NUM_CHIPS(NUM_CHIPS), .CNT_W(CNT_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .thresh(thresh),
    .corrValid(corrValid), .corrChip(corrChip),
    .macResValid(macResValid), .macMismatch(macMismatch),
    .failValid(failValid), .failChip(failChip), .searchReq(searchReq),
    .patchCmd(patchCmd)
  );

  fct_datapath #(.NUM_CHIPS(NUM_CHIPS), .SLICE_W(SLICE_W), .LINE_W(LINE_W)) dp_i (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .rdLine(rdLine), .rdParity(rdParity),
    .patchCmd(patchCmd), .outValid(outValid), .outLine(outLine), .outPatched(outPatched)
  );
endmodule

// File: tb/fault_chip_tracker_tb_top.sv
`timescale 1ns/1ps
module fault_chip_tracker_tb_top;
  localparam int NCH = 9;
  localparam int SW  = 64;
  localparam int CW  = 8;
  localparam int IW  = $clog2(NCH);
  localparam int LW  = NCH * SW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clearIn = 1'b0;
  logic [CW-1:0] thresh = '0;
  logic          corrValid = 1'b0;
  logic [IW-1:0] corrChip = '0;
  logic          rdValid = 1'b0;
  logic [LW-1:0] rdLine = '0;
  logic [SW-1:0] rdParity = '0;
  logic          macResValid = 1'b0;
  logic          macMismatch = 1'b0;
  logic          outValid;
  logic [LW-1:0] outLine;
  logic          outPatched;
  logic          failValid;
  logic [IW-1:0] failChip;
  logic          searchReq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  fault_chip_tracker #(.NUM_CHIPS(NCH), .SLICE_W(SW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .thresh(thresh),
    .corrValid(corrValid), .corrChip(corrChip), .rdValid(rdValid), .rdLine(rdLine),
    .rdParity(rdParity), .macResValid(macResValid), .macMismatch(macMismatch),
    .outValid(outValid), .outLine(outLine), .outPatched(outPatched),
    .failValid(failValid), .failChip(failChip), .searchReq(searchReq)
  );

  // Correction event table: chip reported, expected marked chip afterwards (-1 = none), requirement.
  // thresh = 3. Entry 2 uses out-of-range chip 9 (R4); entry 6 shows first-wins (R5); entry 5 marks (R3).
  localparam int NV = 8;
  localparam int VCHIP [NV] = '{2, 5, 9, 2, 5, 5, 2, 0};
  localparam int VEXP  [NV] = '{-1, -1, -1, -1, -1, 5, 5, 5};
  localparam int VREQ  [NV] = '{3, 3, 4, 3, 3, 3, 5, 5};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] makeLine(input int seed);
    logic [LW-1:0] l;
    for (int i = 0; i < NCH; i++)
      l[i*SW +: SW] = {32'(seed * 7 + i), 32'hC0DE_0000 ^ 32'(i * 13 + seed)};
    return l;
  endfunction

  function automatic logic [SW-1:0] parityOf(input logic [LW-1:0] l);
    logic [SW-1:0] p = '0;
    for (int i = 0; i < NCH; i++) p = p ^ l[i*SW +: SW];
    return p;
  endfunction

  function automatic logic [LW-1:0] corrupt(input logic [LW-1:0] l, input int k);
    logic [LW-1:0] r = l;
    r[k*SW +: SW] = r[k*SW +: SW] ^ 64'hFFFF_0000_1234_5678;
    return r;
  endfunction

  task automatic corr(input int c);
    @(negedge clk);
    corrValid = 1'b1;
    corrChip  = IW'(c);
    @(negedge clk);
    corrValid = 1'b0;
  endtask

  task automatic readLine(input logic [LW-1:0] l, input logic [SW-1:0] p);
    @(negedge clk);
    rdValid  = 1'b1;
    rdLine   = l;
    rdParity = p;
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic mism();
    @(negedge clk);
    macResValid = 1'b1;
    macMismatch = 1'b1;
    @(negedge clk);
    macResValid = 1'b0;
    macMismatch = 1'b0;
  endtask

  task automatic chkMark(input int exp, input string req);
    if (exp < 0) check(failValid == 1'b0, req, "failValid", LW'(failValid), '0);
    else begin
      check(failValid == 1'b1, req, "failValid", LW'(failValid), LW'(1));
      check(failChip == IW'(exp), req, "failChip", LW'(failChip), LW'(exp));
    end
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [LW-1:0] good;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!failValid, "R1", "failValid", LW'(failValid), '0);
    check(!outValid, "R1", "outValid", LW'(outValid), '0);
    check(!searchReq, "R1", "searchReq", LW'(searchReq), '0);
    rstN = 1'b1;
    @(negedge clk);
    check(!failValid && !outValid, "R1", "after release", LW'({failValid, outValid}), '0);

    // R2 pass-through
    good = makeLine(1);
    readLine(good, parityOf(good) ^ 64'h1);
    check(outValid, "R2", "outValid", LW'(outValid), LW'(1));
    check(outLine == good, "R2", "outLine", outLine, good);
    check(!outPatched, "R2", "outPatched", LW'(outPatched), '0);
    @(negedge clk);
    check(!outValid, "R2", "outValid idle", LW'(outValid), '0);

    // Table walk: counting, ignored index, first wins
    thresh = 8'd3;
    for (int v = 0; v < NV; v++) begin
      corr(VCHIP[v]);
      chkMark(VEXP[v], $sformatf("R%0d", VREQ[v]));
    end

    // R7 patch of data chip 5
    good = makeLine(10);
    readLine(corrupt(good, 5), parityOf(good));
    check(outLine == good, "R7", "rebuilt line", outLine, good);
    check(outPatched, "R7", "outPatched", LW'(outPatched), LW'(1));
    readLine(good, parityOf(good));
    check(outLine == good, "R7", "clean line rebuilt", outLine, good);

    // R8 mismatch on patched line
    mism();
    chkMark(-1, "R8");
    check(searchReq, "R8", "searchReq", LW'(searchReq), LW'(1));
    @(negedge clk);
    check(!searchReq, "R8", "searchReq pulse", LW'(searchReq), '0);
    readLine(corrupt(good, 5), parityOf(good));
    check(outLine == corrupt(good, 5) && !outPatched, "R8", "no patch after unmark",
          outLine, corrupt(good, 5));
    corr(5);
    chkMark(-1, "R8");  // count of chip 5 was zeroed
    corr(2);
    chkMark(2, "R3");   // chip 2 count 3 -> 4

    // R10 clear
    @(negedge clk);
    clearIn = 1'b1;
    @(negedge clk);
    clearIn = 1'b0;
    chkMark(-1, "R10");
    corr(2);
    chkMark(-1, "R10");
    thresh = 8'd1;
    @(negedge clk);
    clearIn   = 1'b1;
    corrValid = 1'b1;
    corrChip  = IW'(4);
    @(negedge clk);
    clearIn   = 1'b0;
    corrValid = 1'b0;
    chkMark(-1, "R10");

    // R9 mismatch with nothing marked
    mism();
    check(!searchReq, "R9", "searchReq", LW'(searchReq), '0);
    chkMark(-1, "R9");

    // R11 thresh 1, tag chip (slice 8)
    corr(8);
    chkMark(8, "R11");
    good = makeLine(33);
    readLine(corrupt(good, 8), parityOf(good));
    check(outLine == good, "R11", "tag slice rebuilt", outLine, good);

    // R6 saturation: 300 events on chip 3 while chip 8 holds the mark
    thresh = 8'd255;
    @(negedge clk);
    corrValid = 1'b1;
    corrChip  = IW'(3);
    repeat (300) @(negedge clk);
    corrValid = 1'b0;
    chkMark(8, "R5");
    mism();
    chkMark(-1, "R8");
    corr(3);
    chkMark(3, "R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule